// File: doc/BRIEF.md
# Dual-Mode Panel Pixel Output Formatter

This block takes a recovered pixel stream, one 24-bit pixel per input clock made of three 8-bit colour channels with a data-enable, two sync bits and three control bits, and drives a flat-panel output port. The output bus is 36 bits wide. In single mode it carries one full-depth pixel per clock. In pair mode it carries two pixels per output clock, each cut to 6 bits per channel. The block also generates the panel clock. It sets the clock polarity, can stop the clock during blanking, and produces the output-enable that stands for the tri-state power-down of the output drivers.

Two active-low power-down inputs control the outputs. The output power-down disables the drivers only. The full power-down also freezes every internal register. A data-enable activity detector and control bit 0 stay driven in every power state. The sync-detect flag and control bit 0 keep the values they held when the full power-down began.

Top module: `pix_out_fmt`

## Requirements
- R1: With pair_mode_i low, the edge that samples pix_i = {ch2,ch1,ch0} loads q_o[23:0] with that pixel when de_i is high and with zero when de_i is low. q_o[35:24] is always zero.
- R2: With pair_mode_i high, the first active pixel after de_i rises is the even pixel, and the next is its odd partner. At the odd pixel's edge, q_o[17:0] takes the reduced even pixel and q_o[35:18] takes the reduced odd pixel. A reduced pixel is {ch2[7:2],ch1[7:2],ch0[7:2]}. The pair then holds for two clocks.
- R3: In pair mode, if de_i is low at the edge after an unpartnered even pixel, that even pixel is output in q_o[17:0] with q_o[35:18] zero and de_o high.
- R4: de_o, hs_o, vs_o and ctl_o load at the same edge as q_o. In single mode that is every edge. In pair mode it is every edge except the even-capture edge.
- R5: With clk_inv_i low, pclk_o equals clk_i in single mode. In pair mode pclk_o is a half-rate clock: low after an even-capture edge, high after an odd edge, and toggling on each edge while de_i is low. With clk_inv_i high, pclk_o is the complement.
- R6: With gate_clk_i high, pclk_o is low while de_o is low. With gate_clk_i low, the clock is not gated.
- R7: With out_pd_ni low, drv_en_o is low and q_o, pclk_o, de_o, hs_o, vs_o, ctl_o[2:1] read zero. ctl_o[0] and sync_det_o stay driven.
- R8: With full_pd_ni low, the outputs behave as in R7. All internal state, including the sync detector, also holds, and processing resumes from that state.
- R9: sync_det_o is low after reset. It is high for SD_WIN (16) clocks after an edge that samples a change of de_i, and low once SD_WIN clocks pass with no change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_i | input | 24 | Pixel {ch2,ch1,ch0} |
| de_i | input | 1 | Input data enable |
| hs_i | input | 1 | Horizontal sync |
| vs_i | input | 1 | Vertical sync |
| ctl_i | input | 3 | Control bits |
| pair_mode_i | input | 1 | 1: two pixels per output clock |
| gate_clk_i | input | 1 | 1: stop pclk_o during blanking |
| clk_inv_i | input | 1 | 1: invert pclk_o |
| out_pd_ni | input | 1 | Output power-down, active low |
| full_pd_ni | input | 1 | Full power-down, active low |
| q_o | output | 36 | Output pixel bus |
| pclk_o | output | 1 | Panel clock |
| de_o | output | 1 | Output data enable |
| hs_o | output | 1 | Output horizontal sync |
| vs_o | output | 1 | Output vertical sync |
| ctl_o | output | 3 | Output control bits; bit 0 never disabled |
| sync_det_o | output | 1 | Data-enable activity flag |
| drv_en_o | output | 1 | Output-driver enable |

## Verification
Clock gating and the orphan flush fall in the same cycle. When an odd-length line ends in pair mode, the flushed half-pair raises de_o in the first blanking cycle, so pclk_o must keep running for exactly that beat and stop on the next. Random line lengths of both parities are run under random gating and polarity so that this case occurs many times. At each edge, pclk_o is compared at both clock levels against a bench model of the half-rate phase.

// File: rtl/pof_pkg.sv
package pof_pkg;
  localparam int unsigned CTL_W = 3;

  typedef struct packed {
    logic             hs;
    logic             vs;
    logic [CTL_W-1:0] ctl;
  } side_t;
endpackage

// File: rtl/pof_pack.sv
module pof_pack
  import pof_pkg::*;
#(
  parameter int unsigned CH_W   = 8,
  parameter int unsigned PAIR_W = 6,
  localparam int unsigned PIX_W  = 3 * CH_W,
  localparam int unsigned HALF_W = 3 * PAIR_W,
  localparam int unsigned OUT_W  = 2 * HALF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             pair_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             de_i,
  input  side_t            side_i,
  output logic [OUT_W-1:0] q_o,
  output logic             de_o,
  output side_t            side_o,
  output logic             phase_o
);
  logic [HALF_W-1:0] red;
  logic [HALF_W-1:0] even_r;
  logic [OUT_W-1:0]  q_r;
  logic              de_r, phase_r;
  side_t             side_r;

  for (genvar c = 0; c < 3; c++) begin : g_red
    assign red[c*PAIR_W +: PAIR_W] = pix_i[c*CH_W + (CH_W-PAIR_W) +: PAIR_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_r     <= '0;
      de_r    <= 1'b0;
      side_r  <= '0;
      even_r  <= '0;
      phase_r <= 1'b0;
    end else if (run_i) begin
      if (!pair_i) begin
        phase_r <= 1'b0;
        de_r    <= de_i;
        side_r  <= side_i;
        q_r     <= '0;
        if (de_i) q_r[PIX_W-1:0] <= pix_i;
      end else if (de_i && !phase_r) begin
        even_r  <= red;        // hold outputs, wait for odd partner
        phase_r <= 1'b1;
      end else begin
        phase_r <= 1'b0;
        de_r    <= de_i | phase_r;
        side_r  <= side_i;
        q_r     <= '0;
        if (de_i)         q_r <= {red, even_r};
        else if (phase_r) q_r[HALF_W-1:0] <= even_r;  // orphan flush
      end
    end
  end

  assign q_o     = q_r;
  assign de_o    = de_r;
  assign side_o  = side_r;
  assign phase_o = phase_r;

  AST_SINGLE_UPPER_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !pair_i) |=> (q_r[OUT_W-1:PIX_W] == '0)); // R1
  AST_EVEN_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && pair_i && de_i && !phase_r) |=> ($stable(q_r) && phase_r)); // R2
  AST_ORPHAN_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && pair_i && !de_i && phase_r) |=> (de_r && !phase_r && q_r[OUT_W-1:HALF_W] == '0)); // R3
  AST_HALT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> ($stable(q_r) && $stable(phase_r) && $stable(side_r) && $stable(de_r))); // R8
endmodule

// File: rtl/pof_clkout.sv
module pof_clkout (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic pair_i,
  input  logic de_i,
  input  logic phase_i,
  input  logic inv_i,
  input  logic gate_i,
  input  logic de_out_i,
  output logic pclk_o
);
  logic half_r, base, pol;

  // half-rate phase: low after even capture, high after odd, free-running in blanking
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    half_r <= 1'b0;
    else if (run_i) half_r <= de_i ? phase_i : ~half_r;
  end

  assign base   = pair_i ? half_r : clk_i;
  assign pol    = base ^ inv_i;
  assign pclk_o = (gate_i && !de_out_i) ? 1'b0 : pol;

  AST_HALF_AFTER_ODD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && de_i && phase_i) |=> half_r); // R5
  AST_HALF_AFTER_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && de_i && !phase_i) |=> !half_r); // R5
endmodule

// File: rtl/pof_sync_det.sv
module pof_sync_det #(
  parameter int unsigned WIN = 16,
  localparam int unsigned CW = $clog2(WIN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic de_i,
  output logic det_o
);
  logic [CW-1:0] cnt_r;
  logic          de_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_r <= CW'(WIN);
      de_q  <= 1'b0;
    end else if (run_i) begin
      de_q <= de_i;
      if (de_i != de_q)           cnt_r <= '0;
      else if (cnt_r != CW'(WIN)) cnt_r <= cnt_r + 1'b1;
    end
  end

  assign det_o = (cnt_r != CW'(WIN));

  AST_DET_ON_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && (de_i != de_q)) |=> det_o); // R9
endmodule

// File: rtl/pix_out_fmt.sv
module pix_out_fmt
  import pof_pkg::*;
#(
  parameter int unsigned CH_W   = 8,
  parameter int unsigned PAIR_W = 6,
  parameter int unsigned SD_WIN = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [3*CH_W-1:0]     pix_i,
  input  logic                  de_i,
  input  logic                  hs_i,
  input  logic                  vs_i,
  input  logic [CTL_W-1:0]      ctl_i,
  input  logic                  pair_mode_i,
  input  logic                  gate_clk_i,
  input  logic                  clk_inv_i,
  input  logic                  out_pd_ni,
  input  logic                  full_pd_ni,
  output logic [6*PAIR_W-1:0]   q_o,
  output logic                  pclk_o,
  output logic                  de_o,
  output logic                  hs_o,
  output logic                  vs_o,
  output logic [CTL_W-1:0]      ctl_o,
  output logic                  sync_det_o,
  output logic                  drv_en_o
);
  localparam int unsigned OUT_W = 6 * PAIR_W;

  logic [OUT_W-1:0] q_int;
  logic             de_int, phase, pclk_int, en;
  side_t            side_in, side_int;

  assign side_in = '{hs: hs_i, vs: vs_i, ctl: ctl_i};

  pof_pack #(.CH_W(CH_W), .PAIR_W(PAIR_W)) u_pack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (full_pd_ni),
    .pair_i (pair_mode_i),
    .pix_i  (pix_i),
    .de_i   (de_i),
    .side_i (side_in),
    .q_o    (q_int),
    .de_o   (de_int),
    .side_o (side_int),
    .phase_o(phase)
  );

  pof_clkout u_clk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (full_pd_ni),
    .pair_i  (pair_mode_i),
    .de_i    (de_i),
    .phase_i (phase),
    .inv_i   (clk_inv_i),
    .gate_i  (gate_clk_i),
    .de_out_i(de_int),
    .pclk_o  (pclk_int)
  );

  pof_sync_det #(.WIN(SD_WIN)) u_sd (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (full_pd_ni),
    .de_i  (de_i),
    .det_o (sync_det_o)
  );

  // disabled drivers read as pulled low; ctl bit 0 stays driven
  assign en       = out_pd_ni & full_pd_ni;
  assign drv_en_o = en;
  assign q_o      = en ? q_int : '0;
  assign pclk_o   = en & pclk_int;
  assign de_o     = en & de_int;
  assign hs_o     = en & side_int.hs;
  assign vs_o     = en & side_int.vs;
  assign ctl_o    = {side_int.ctl[CTL_W-1:1] & {(CTL_W-1){en}}, side_int.ctl[0]};

  AST_PD_DRIVERS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_pd_ni |-> (q_o == '0 && !de_o && !hs_o && !vs_o)); // R7
endmodule

// File: tb/pix_out_fmt_test.sv
`timescale 1ns/1ps
module pix_out_fmt_test;
  localparam int WIN = 16;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic [23:0] pix_i = '0;
  logic        de_i = 0, hs_i = 0, vs_i = 0;
  logic [2:0]  ctl_i = '0;
  logic        pair_mode_i = 0, gate_clk_i = 0, clk_inv_i = 0;
  logic        out_pd_ni = 1, full_pd_ni = 1;
  logic [35:0] q_o;
  logic        pclk_o, de_o, hs_o, vs_o, sync_det_o, drv_en_o;
  logic [2:0]  ctl_o;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pix_out_fmt uut (
    .clk_i(clk), .rst_ni(rst_ni), .pix_i(pix_i), .de_i(de_i), .hs_i(hs_i), .vs_i(vs_i),
    .ctl_i(ctl_i), .pair_mode_i(pair_mode_i), .gate_clk_i(gate_clk_i), .clk_inv_i(clk_inv_i),
    .out_pd_ni(out_pd_ni), .full_pd_ni(full_pd_ni), .q_o(q_o), .pclk_o(pclk_o), .de_o(de_o),
    .hs_o(hs_o), .vs_o(vs_o), .ctl_o(ctl_o), .sync_det_o(sync_det_o), .drv_en_o(drv_en_o)
  );

  // reference state
  logic [35:0] m_q = '0;
  logic [17:0] m_even = '0;
  logic [4:0]  m_side = '0;
  logic        m_de = 0, m_phase = 0, m_half = 0, m_deq = 0, m_orph = 0;
  int          m_cnt = WIN;

  function automatic logic [17:0] red6(logic [23:0] p);
    return {p[23:18], p[15:10], p[7:2]};
  endfunction

  task automatic chk(string tag, logic [35:0] got, logic [35:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_step();
    if (!full_pd_ni) return;
    if (de_i != m_deq) m_cnt = 0; else if (m_cnt != WIN) m_cnt++;
    m_deq  = de_i;
    m_half = de_i ? m_phase : ~m_half;
    if (!pair_mode_i) begin
      m_phase = 0; m_orph = 0;
      m_de = de_i; m_side = {hs_i, vs_i, ctl_i};
      m_q = de_i ? {12'b0, pix_i} : '0;
    end else if (de_i && !m_phase) begin
      m_even = red6(pix_i); m_phase = 1;
    end else begin
      m_orph = !de_i && m_phase;
      m_q = de_i ? {red6(pix_i), m_even} : (m_phase ? {18'b0, m_even} : '0);
      m_de = de_i | m_phase;
      m_phase = 0;
      m_side = {hs_i, vs_i, ctl_i};
    end
  endtask

  task automatic check_clk(logic lvl);
    logic en, base, exp;
    string tag;
    en   = out_pd_ni & full_pd_ni;
    base = pair_mode_i ? m_half : lvl;
    exp  = (gate_clk_i && !m_de) ? 1'b0 : (base ^ clk_inv_i);
    tag  = !en ? (full_pd_ni ? "R7" : "R8") : ((gate_clk_i && !m_de) ? "R6" : "R5");
    chk(tag, {35'b0, pclk_o}, {35'b0, en & exp});
  endtask

  task automatic check_hi();
    logic en;
    string tq;
    en = out_pd_ni & full_pd_ni;
    tq = !en ? (full_pd_ni ? "R7" : "R8") : (pair_mode_i ? (m_orph ? "R3" : "R2") : "R1");
    chk(tq, q_o, en ? m_q : '0);
    chk(en ? "R4" : "R7", {31'b0, de_o, hs_o, vs_o, ctl_o[2:1]},
        en ? {31'b0, m_de, m_side[4:1]} : '0);
    chk("R7", {34'b0, drv_en_o, ctl_o[0]}, {34'b0, en, m_side[0]});
    chk("R9", {35'b0, sync_det_o}, {35'b0, m_cnt != WIN});
    check_clk(1'b1);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    #1 check_hi();
    @(negedge clk);
    #1 check_clk(1'b0);
  endtask

  task automatic drive(logic de, logic [23:0] p);
    de_i = de; pix_i = p;
    hs_i = $urandom % 2; vs_i = $urandom % 2; ctl_i = $urandom % 8;
    tick();
  endtask

  task automatic line(int act, int blank);
    for (int i = 0; i < act; i++) drive(1'b1, $urandom);
    for (int i = 0; i < blank; i++) drive(1'b0, $urandom);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0141));
    repeat (3) @(negedge clk);
    #1;
    chk("R1", q_o, '0);
    chk("R9", {35'b0, sync_det_o}, '0);
    chk("R4", {35'b0, de_o}, '0);
    rst_ni = 1'b1;

    // directed: single mode, known pixel, then blanking
    drive(1'b1, 24'hA5_3C_F0);
    chk("R1", q_o, 36'h0_00A5_3CF0);
    line(5, 4);
    // directed: pair mode odd-length line -> orphan flush under gating
    pair_mode_i = 1; gate_clk_i = 1;
    drive(1'b1, 24'hFC_84_0C);
    drive(1'b1, 24'h03_FF_80);
    chk("R2", q_o, {6'h00, 6'h3F, 6'h20, 6'h3F, 6'h21, 6'h03});
    drive(1'b1, 24'hFF_FF_FF);
    drive(1'b0, 24'h0);
    chk("R3", q_o, {18'b0, 18'h3FFFF});
    line(0, 4);
    // directed: output power-down keeps ctl bit 0 and sync detect
    out_pd_ni = 0; line(3, 2); out_pd_ni = 1;
    // directed: full power-down freezes state mid-pair
    drive(1'b1, 24'h123456);
    full_pd_ni = 0; line(2, 2); full_pd_ni = 1;
    line(4, 3);

    // random segments
    for (int seg = 0; seg < 40; seg++) begin
      pair_mode_i = $urandom % 2;
      gate_clk_i  = $urandom % 2;
      clk_inv_i   = $urandom % 2;
      for (int l = 0; l < 3; l++) begin
        int act, blank;
        act   = 1 + $urandom % 9;
        blank = 1 + $urandom % 5;
        for (int i = 0; i < act + blank; i++) begin
          out_pd_ni  = (seg % 4 == 1) ? (($urandom % 8) != 0) : 1'b1;
          full_pd_ni = (seg % 4 == 3) ? (($urandom % 10) != 0) : 1'b1;
          drive(i < act, $urandom);
        end
      end
      out_pd_ni = 1; full_pd_ni = 1;
    end

    // long blanking: sync detect must fall
    for (int i = 0; i < WIN + 8; i++) drive(1'b0, '0);
    chk("R9", {35'b0, sync_det_o}, '0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule